// File: doc/BRIEF.md
# Run-Time Programmable CRC-16 Engine

This block computes a 16-bit cyclic redundancy check one bit per clock. The generator polynomial is set at run time through two byte-wide configuration registers. The x^16 term is always present and is never stored. A third register address holds an enable bit for checking on the receive side. Software programs the polynomial once, and each packet then runs from a start strobe to an end strobe. Serial data bits are presented with a valid qualifier.

In transmit mode the engine absorbs the payload bits. After the end strobe it shifts the 16-bit remainder out serially, most significant bit first, and pulses a done signal after the last bit. In receive mode it absorbs the payload followed by the 16 received check bits. One cycle after the end strobe it pulses done together with a pass flag when the register reads zero. The pass pulse is meant to feed an interrupt. Polynomial writes made while a packet is running are held back until the next start strobe.

Top module: `crc16_prog_engine`

## Requirements
- R1: Configuration address 0 writes polynomial coefficient bits 15..8 and address 1 writes bits 7..0. The x^16 coefficient is implied. After reset the polynomial is 0x8005 (x^16+x^15+x^2+1).
- R2: Configuration address 2, bit 0, is the receive-check enable. It resets to 0.
- R3: A start strobe in any state clears the shift register to 0x0000 and begins a new packet. It takes the polynomial, the enable and the mode (tx_mode=1 for transmit) as they stand before any write in the same cycle. After reset, and while idle, all outputs are low.
- R4: While a packet is being absorbed, a bit is taken, most significant first, only in a cycle where the valid input is high. Cycles where valid is low leave the result unchanged.
- R5: In transmit mode, the cycle after the end strobe begins exactly 16 cycles with the CRC valid output high. These cycles carry the remainder, bit 15 first.
- R6: In transmit mode, done pulses for one cycle immediately after the 16th remainder bit, and pass stays low.
- R7: In receive mode with the enable set, done pulses one cycle after the end strobe. Pass pulses in the same cycle exactly when the register is zero after all bits have been absorbed.
- R8: In receive mode with the enable clear, neither done nor pass is raised.
- R9: A polynomial write during a packet does not affect that packet. It takes effect at the next start strobe.
- R10: With polynomial 0x8005, the ASCII string "123456789" gives remainder 0xFEE8. Writing 0x3D then 0x65 selects polynomial 0x3D65, and a packet followed by its own remainder then passes the check.
- R11: Data bits presented outside a packet, or in the same cycle as the end strobe, are not absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 upper poly byte, 1 lower poly byte, 2 control) |
| cfg_wdata | input | 8 | Configuration write data |
| tx_mode | input | 1 | Packet mode sampled at start: 1 transmit, 0 receive |
| pkt_start | input | 1 | Start-of-packet strobe |
| pkt_end | input | 1 | End-of-packet strobe |
| bit_in | input | 1 | Serial data bit |
| bit_in_vld | input | 1 | Data bit qualifier |
| crc_bit | output | 1 | Serial remainder bit |
| crc_bit_vld | output | 1 | Remainder bit qualifier |
| chk_done | output | 1 | One-cycle completion pulse |
| chk_pass | output | 1 | One-cycle CRC-verified pulse |

## Verification
Several properties are checked on every cycle. The assertions require that the active polynomial only changes at a start strobe and that the register is zero after a start. They also require that a running remainder shift is never cut short except by a new start, that done never lasts two cycles, that pass never appears without done, and that a receive completion only happens with the enable latched. Other behaviour needs the bench's scenarios. These cover the numeric correctness of remainders under both polynomials, the known check value, the deferred effect of a mid-packet polynomial write, and the rejection of gapped, stray and end-cycle data bits. They also cover a corrupted packet failing and a start strobe aborting a shift. The reference model predicts all four outputs each clock.

// File: rtl/crc16_eng_pkg.sv
package crc16_eng_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ABSORB = 2'd1,
      ST_SHIFT  = 2'd2
   } eng_state_t;
endpackage

// File: rtl/crc_cfg_regs.sv
// Configuration bytes for the polynomial plus the enable bit.
// Staged values are copied to the active set only at a packet start.
module crc_cfg_regs #(
   parameter int          CRC_W      = 16,
   parameter int          CFG_W      = 8,
   parameter int          ADDR_W     = 2,
   parameter logic [15:0] POLY_RESET = 16'h8005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CFG_W-1:0]  wdata,
   input  logic              load,
   output logic [CRC_W-1:0]  poly_act,
   output logic              en_act
);
   localparam int NB = CRC_W / CFG_W;

   logic [CFG_W-1:0] stage_b [NB];
   logic [CRC_W-1:0] stage;
   logic             en_stage;

   generate
      if (CRC_W % CFG_W != 0) begin : g_bad_width
         $error("CRC_W must be a multiple of CFG_W");
      end
      if (NB + 1 > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register set");
      end
      // byte g = 0 is the most significant coefficient byte
      for (genvar g = 0; g < NB; g++) begin : g_byte
         localparam int LO = (NB - 1 - g) * CFG_W;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_b[g] <= POLY_RESET[LO +: CFG_W];
            else if (wr && addr == ADDR_W'(g))
               stage_b[g] <= wdata;
         end
         assign stage[LO +: CFG_W] = stage_b[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_stage <= 1'b0;
      else if (wr && addr == ADDR_W'(NB))
         en_stage <= wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poly_act <= POLY_RESET[CRC_W-1:0];
         en_act   <= 1'b0;
      end else if (load) begin
         poly_act <= stage;
         en_act   <= en_stage;
      end
   end

   assert_poly_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(poly_act) && $stable(en_act));
endmodule

// File: rtl/crc_shift_core.sv
// Bit-serial remainder register, MSB-first, with parallel polynomial taps.
module crc_shift_core #(
   parameter int CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             absorb,
   input  logic             din,
   input  logic             shift,
   input  logic [CRC_W-1:0] poly,
   output logic [CRC_W-1:0] rem
);
   logic             fb;
   logic [CRC_W-1:0] nxt;

   assign fb = din ^ rem[CRC_W-1];

   generate
      if (CRC_W < 2) begin : g_bad
         $error("CRC_W must be at least 2");
      end
      for (genvar i = 0; i < CRC_W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign nxt[i] = fb & poly[i];
         end else begin : g_up
            assign nxt[i] = rem[i-1] ^ (fb & poly[i]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem <= '0;
      else if (clear)
         rem <= '0;
      else if (absorb)
         rem <= nxt;
      else if (shift)
         rem <= {rem[CRC_W-2:0], 1'b0};
   end

   assert_clear_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (rem == '0));
   assert_idle_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !absorb && !shift) |=> $stable(rem));
endmodule

// File: rtl/crc_seq.sv
// Packet sequencer: absorb, remainder shift-out, completion pulses.
module crc_seq
   import crc16_eng_pkg::*;
#(
   parameter int CRC_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sop,
   input  logic eop,
   input  logic din_vld,
   input  logic mode_tx,
   input  logic en_act,
   input  logic rem_zero,
   output logic clear,
   output logic absorb,
   output logic shift,
   output logic out_vld,
   output logic done,
   output logic pass
);
   localparam int CNT_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CRC_W - 1);

   eng_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic             tx_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         tx_lat <= 1'b0;
         done   <= 1'b0;
         pass   <= 1'b0;
      end else begin
         done <= 1'b0;
         pass <= 1'b0;
         if (sop) begin
            state  <= ST_ABSORB;
            tx_lat <= mode_tx;
            cnt    <= '0;
         end else begin
            case (state)
               ST_ABSORB: begin
                  if (eop) begin
                     if (tx_lat) begin
                        state <= ST_SHIFT;
                        cnt   <= '0;
                     end else begin
                        state <= ST_IDLE;
                        done  <= en_act;
                        pass  <= en_act & rem_zero;
                     end
                  end
               end
               ST_SHIFT: begin
                  if (cnt == LAST) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign clear   = sop;
   assign absorb  = (state == ST_ABSORB) && !sop && !eop && din_vld;
   assign shift   = (state == ST_SHIFT) && !sop;
   assign out_vld = (state == ST_SHIFT);

   assert_done_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_pass_needs_done_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done);
   assert_tx_no_pass_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && tx_lat) |-> !pass);
   assert_rx_needs_en_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !tx_lat) |-> en_act);
   assert_shift_run_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !sop) |=> (out_vld || done));
endmodule

// File: rtl/crc16_prog_engine.sv
module crc16_prog_engine #(
   parameter int          CRC_W      = 16,
   parameter int          CFG_W      = 8,
   parameter int          ADDR_W     = 2,
   parameter logic [15:0] POLY_RESET = 16'h8005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              tx_mode,
   input  logic              pkt_start,
   input  logic              pkt_end,
   input  logic              bit_in,
   input  logic              bit_in_vld,
   output logic              crc_bit,
   output logic              crc_bit_vld,
   output logic              chk_done,
   output logic              chk_pass
);
   logic [CRC_W-1:0] poly_act;
   logic             en_act;
   logic [CRC_W-1:0] rem;
   logic             clear, absorb, shift;

   crc_cfg_regs #(
      .CRC_W(CRC_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W), .POLY_RESET(POLY_RESET)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .load(pkt_start), .poly_act(poly_act), .en_act(en_act)
   );

   crc_shift_core #(.CRC_W(CRC_W)) i_core (
      .clk(clk), .rst_n(rst_n), .clear(clear), .absorb(absorb), .din(bit_in),
      .shift(shift), .poly(poly_act), .rem(rem)
   );

   crc_seq #(.CRC_W(CRC_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .sop(pkt_start), .eop(pkt_end),
      .din_vld(bit_in_vld), .mode_tx(tx_mode), .en_act(en_act),
      .rem_zero(rem == '0), .clear(clear), .absorb(absorb), .shift(shift),
      .out_vld(crc_bit_vld), .done(chk_done), .pass(chk_pass)
   );

   assign crc_bit = crc_bit_vld & rem[CRC_W-1];

   assert_out_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !crc_bit_vld |-> !crc_bit);
endmodule

// File: tb/test_crc16_prog_engine.sv
module test_crc16_prog_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       tx_mode = 1'b0;
   logic       pkt_start = 1'b0;
   logic       pkt_end = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_in_vld = 1'b0;
   logic       crc_bit, crc_bit_vld, chk_done, chk_pass;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   crc16_prog_engine i_crc16_prog_engine (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .tx_mode(tx_mode), .pkt_start(pkt_start),
      .pkt_end(pkt_end), .bit_in(bit_in), .bit_in_vld(bit_in_vld),
      .crc_bit(crc_bit), .crc_bit_vld(crc_bit_vld), .chk_done(chk_done),
      .chk_pass(chk_pass)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // polynomial long division of msg * x^16 by {1,poly}
   function automatic logic [15:0] ref_rem(input bit msg[$], input logic [15:0] poly);
      bit a[$];
      logic [16:0] g;
      logic [15:0] r;
      g = {1'b1, poly};
      a = msg;
      for (int k = 0; k < 16; k++) a.push_back(1'b0);
      for (int i = 0; i < msg.size(); i++)
         if (a[i])
            for (int j = 0; j <= 16; j++) a[i+j] ^= g[16-j];
      for (int k = 0; k < 16; k++) r[15-k] = a[msg.size()+k];
      return r;
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_stage, m_poly, m_rem;
   bit          m_en_stage, m_en, m_tx;
   int          m_phase, m_cnt;
   bit          m_bits[$];
   bit          exp_vld, exp_out, exp_done, exp_ok;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stage = 16'h8005; m_poly = 16'h8005; m_en_stage = 0; m_en = 0;
         m_tx = 0; m_phase = 0; m_cnt = 0; m_rem = 0; m_bits.delete();
         exp_done = 0; exp_ok = 0;
      end else begin
         exp_done = 0; exp_ok = 0;
         if (pkt_start) begin
            m_phase = 1; m_bits.delete(); m_poly = m_stage; m_en = m_en_stage;
            m_tx = tx_mode;
         end else if (m_phase == 1) begin
            if (pkt_end) begin
               m_rem = ref_rem(m_bits, m_poly);
               if (m_tx) begin m_phase = 2; m_cnt = 0; end
               else begin
                  m_phase = 0; exp_done = m_en; exp_ok = m_en && (m_rem == 0);
               end
            end else if (bit_in_vld) m_bits.push_back(bit_in);
         end else if (m_phase == 2) begin
            m_cnt++;
            if (m_cnt == 16) begin m_phase = 0; exp_done = 1; end
         end
         if (cfg_wr) begin
            if (cfg_addr == 2'd0) m_stage[15:8] = cfg_wdata;
            if (cfg_addr == 2'd1) m_stage[7:0] = cfg_wdata;
            if (cfg_addr == 2'd2) m_en_stage = cfg_wdata[0];
         end
      end
      exp_vld = (m_phase == 2);
      exp_out = exp_vld ? m_rem[15-m_cnt] : 1'b0;
   end

   // ---------------- per-cycle comparison and capture ----------------
   logic [15:0] got;
   int          n_done = 0, n_pass = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         check(crc_bit_vld == exp_vld, "R5 crc_bit_vld", crc_bit_vld, exp_vld);
         if (exp_vld) check(crc_bit == exp_out, "R5 crc_bit", crc_bit, exp_out);
         check(chk_done == exp_done, m_tx ? "R6 chk_done" : "R7 chk_done", chk_done, exp_done);
         check(chk_pass == exp_ok, "R7 chk_pass", chk_pass, exp_ok);
         if (crc_bit_vld) got = {got[14:0], crc_bit};
         if (chk_done) n_done++;
         if (chk_pass) n_pass++;
      end
   end

   // ---------------- drivers ----------------
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cfg(input logic [1:0] a, input logic [7:0] d);
      cfg_wr = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_wr = 0;
   endtask

   task automatic start(input bit tx);
      pkt_start = 1; tx_mode = tx; tick(); pkt_start = 0; tx_mode = 0;
   endtask

   task automatic stop();
      pkt_end = 1; tick(); pkt_end = 0;
   endtask

   task automatic send(input logic [7:0] b, input bit gaps);
      for (int i = 7; i >= 0; i--) begin
         bit_in_vld = 1; bit_in = b[i]; tick();
         if (gaps) begin bit_in_vld = 0; bit_in = ~b[i]; tick(); end
      end
      bit_in_vld = 0; bit_in = 0;
   endtask

   function automatic void push_bytes(ref bit q[$], input logic [7:0] b);
      for (int i = 7; i >= 0; i--) q.push_back(b[i]);
   endfunction

   logic [7:0] digits [9];
   bit q[$];
   int d0, p0;

   initial begin
      for (int i = 0; i < 9; i++) digits[i] = 8'h31 + 8'(i);
      repeat (3) tick();
      check(crc_bit_vld == 0 && chk_done == 0 && chk_pass == 0 && crc_bit == 0,
            "R3 reset outputs", {crc_bit_vld, chk_done, chk_pass}, 0);
      rst_n = 1; tick();

      // R10 / R1: default polynomial on the standard check string
      start(1);
      foreach (digits[i]) send(digits[i], 0);
      stop(); repeat (20) tick();
      check(got == 16'hFEE8, "R10 R1 default poly check value", got, 16'hFEE8);

      // R8 / R2: enable still clear after reset, valid packet raises nothing
      d0 = n_done; p0 = n_pass;
      start(0);
      foreach (digits[i]) send(digits[i], 0);
      send(8'hFE, 0); send(8'hE8, 0); stop(); repeat (3) tick();
      check(n_done == d0 && n_pass == p0, "R8 R2 disabled check silent", n_done - d0, 0);

      // R7: enable, good packet passes
      cfg(2'd2, 8'h01);
      p0 = n_pass;
      start(0);
      foreach (digits[i]) send(digits[i], 0);
      send(8'hFE, 0); send(8'hE8, 0); stop(); repeat (3) tick();
      check(n_pass == p0 + 1, "R7 good packet passes", n_pass - p0, 1);

      // R7: corrupted packet completes but fails
      d0 = n_done; p0 = n_pass;
      start(0);
      foreach (digits[i]) send(i == 4 ? 8'h00 : digits[i], 0);
      send(8'hFE, 0); send(8'hE8, 0); stop(); repeat (3) tick();
      check(n_done == d0 + 1 && n_pass == p0, "R7 bad packet fails", n_pass - p0, 0);

      // R9: mid-packet poly write deferred
      q.delete();
      start(1);
      send(8'hA5, 0); send(8'h3C, 0);
      cfg(2'd0, 8'h3D); cfg(2'd1, 8'h65);
      send(8'h0F, 0); stop(); repeat (20) tick();
      push_bytes(q, 8'hA5); push_bytes(q, 8'h3C); push_bytes(q, 8'h0F);
      check(got == ref_rem(q, 16'h8005), "R9 write deferred", got, ref_rem(q, 16'h8005));

      // R10 / R1: second polynomial, tx then rx with own remainder
      start(1);
      send(8'hA5, 0); send(8'h3C, 0); send(8'h0F, 0); stop(); repeat (20) tick();
      check(got == ref_rem(q, 16'h3D65), "R10 R1 poly 3D65 tx", got, ref_rem(q, 16'h3D65));
      p0 = n_pass;
      start(0);
      send(8'hA5, 0); send(8'h3C, 0); send(8'h0F, 0);
      send(got[15:8], 0); send(got[7:0], 0); stop(); repeat (3) tick();
      check(n_pass == p0 + 1, "R10 poly 3D65 rx passes", n_pass - p0, 1);

      // R4 / R11: gaps, stray bits outside packet, data during end strobe
      bit_in_vld = 1; bit_in = 1; tick(); tick(); bit_in_vld = 0;
      start(1);
      send(8'h5A, 1); send(8'hC3, 1);
      bit_in_vld = 1; bit_in = 1; pkt_end = 1; tick();
      pkt_end = 0; bit_in_vld = 0; bit_in = 0;
      repeat (20) tick();
      q.delete(); push_bytes(q, 8'h5A); push_bytes(q, 8'hC3);
      check(got == ref_rem(q, 16'h3D65), "R4 R11 ignored bits", got, ref_rem(q, 16'h3D65));

      // R3: start strobe aborts a running shift
      start(1); send(8'h77, 0); stop(); repeat (5) tick();
      check(crc_bit_vld == 1, "R5 shift running", crc_bit_vld, 1);
      d0 = n_done;
      start(1); tick();
      check(crc_bit_vld == 0, "R3 restart aborts shift", crc_bit_vld, 0);
      send(8'h12, 0); stop(); repeat (20) tick();
      q.delete(); push_bytes(q, 8'h12);
      check(got == ref_rem(q, 16'h3D65) && n_done == d0 + 1, "R3 restart result",
            got, ref_rem(q, 16'h3D65));

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule